// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a logical address into a physical address for a paged memory system. The low `OFS_W` bits of the logical address are the byte offset inside a page and pass through unchanged; the remaining upper bits select a page. A small fully associative translation cache holds recently used page-table entries. When the page is in the cache, the frame number comes from there. When it is not, the block reads the page-table entry over a dedicated read port, stores it in the cache, and then finishes the translation.

Every page-table entry holds a frame number, a present flag and a write-protect flag. The permission check runs alongside address formation. An access to a non-present page, or a write to a protected page, produces a fault pulse with a cause code instead of an address. A single-cycle flush input drops every cached translation. It is used after the page table changes.

Requests use a valid/ready handshake and are handled one at a time. Each accepted request ends in exactly one result pulse: either a response carrying the physical address, or a fault.

Top module: `pat_translator`

## Requirements
- R1: While and directly after reset, `req_ready` is 1 and `rsp_valid`, `fault_valid` and `pt_req` are 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` then stays 0 until the cycle in which that request's result appears, and is 1 again in that cycle.
- R3: The physical address is the frame number placed above the unchanged offset, `{frame, addr[OFS_W-1:0]}`. For example, with 4-bit offsets, frame 0x2B and offset 0xD give 0x2BD.
- R4: On a cache hit, the result appears in the cycle after the request is taken, and `pt_req` stays 0 throughout.
- R5: On a miss, `pt_req` is 1 for exactly one cycle, starting the cycle after the request is taken, with `pt_addr = pt_base + page * PTE_BYTES`. The result appears in the cycle after the cycle in which `pt_rvalid` is 1.
- R6: In the page-table entry, bits `[FRAME_W-1:0]` hold the frame, bit `FRAME_W` is write-protect and bit `FRAME_W+1` is present. A non-present entry gives `fault_valid` with `fault_cause` 0, no `rsp_valid`, and `rsp_paddr` 0.
- R7: A write to a present, write-protected page gives `fault_valid` with `fault_cause` 1 and `rsp_paddr` 0. A read of that page translates normally. A non-present page reports cause 0 even for a write.
- R8: An entry fetched for a faulting translation is still cached. Repeating the access faults again without a page-table read.
- R9: The cache holds `TLB_N` entries and never holds two copies of one page. Each refill writes the slot named by a round-robin pointer that starts at 0 after reset, advances by one per refill, and is not changed by a flush.
- R10: A `tlb_flush` pulse invalidates every entry. Any lookup after it misses. Flush takes priority over a refill in the same cycle.
- R11: `pt_rvalid` is ignored unless a page-table read is outstanding. It neither produces a result nor changes the cache.
- R12: `rsp_valid` and `fault_valid` are never 1 together, and each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tlb_flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Translator can take a request |
| req_addr | input | LADDR_W | Logical address |
| req_write | input | 1 | Access is a write |
| pt_base | input | PT_ADDR_W | Start address of the page table |
| pt_req | output | 1 | Page-table read strobe |
| pt_addr | output | PT_ADDR_W | Page-table entry address |
| pt_rvalid | input | 1 | Page-table read data present |
| pt_rdata | input | FRAME_W+2 | Page-table entry {present, protect, frame} |
| rsp_valid | output | 1 | Translation finished without fault |
| rsp_paddr | output | FRAME_W+OFS_W | Physical address, 0 on fault |
| fault_valid | output | 1 | Translation trapped |
| fault_cause | output | 1 | 0 non-present page, 1 write to protected page |

## Verification
The bench builds the block with 8-bit logical addresses, 4-bit offsets and 6-bit frames. That gives 16 pages, four times the 4-entry cache, so the test reaches evictions, round-robin wrap-around and re-fetch of evicted pages. Entries are 2 bytes wide from a non-zero table base, so the scaled walk address is checked. Read latencies of 0 to 3 cycles cover a same-cycle return and longer waits with a stray read-data strobe in between.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } pat_state_e;

  localparam logic CAUSE_ABSENT  = 1'b0;
  localparam logic CAUSE_PROTECT = 1'b1;
endpackage

// File: rtl/pat_tlb.sv
module pat_tlb #(
  parameter int TLB_N   = 4,
  parameter int VPN_W   = 6,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_pv,
  output logic               lk_ro,
  input  logic               wr_en,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_pv,
  input  logic               wr_ro
);
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [TLB_N-1:0]   used_q;
  logic [TLB_N-1:0]   pv_q;
  logic [TLB_N-1:0]   ro_q;
  logic [TLB_N-1:0]   match;
  logic [VPN_W-1:0]   vpn_q   [TLB_N];
  logic [FRAME_W-1:0] frame_q [TLB_N];
  logic [PTR_W-1:0]   ptr_q;

  generate
    for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
      assign match[g] = used_q[g] && (vpn_q[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_hit   = |match;
    lk_frame = '0;
    lk_pv    = 1'b0;
    lk_ro    = 1'b0;
    for (int i = 0; i < TLB_N; i++) begin
      if (match[i]) begin
        lk_frame = lk_frame | frame_q[i];
        lk_pv    = lk_pv | pv_q[i];
        lk_ro    = lk_ro | ro_q[i];
      end
    end
  end

  // Occupancy flags and replacement pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (wr_en) begin
        ptr_q <= (ptr_q == PTR_W'(TLB_N - 1)) ? '0 : ptr_q + 1'b1;
      end
      for (int i = 0; i < TLB_N; i++) begin
        if (flush) begin
          used_q[i] <= 1'b0;
        end else if (wr_en && (ptr_q == PTR_W'(i))) begin
          used_q[i] <= 1'b1;
        end
      end
    end
  end

  // Entry payload, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < TLB_N; i++) begin
      if (wr_en && (ptr_q == PTR_W'(i))) begin
        vpn_q[i]   <= wr_vpn;
        frame_q[i] <= wr_frame;
        pv_q[i]    <= wr_pv;
        ro_q[i]    <= wr_ro;
      end
    end
  end

  AST_TLB_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit); // R10
endmodule

// File: rtl/pat_xlate.sv
module pat_xlate #(
  parameter int FRAME_W = 8,
  parameter int OFS_W   = 10
) (
  input  logic [FRAME_W-1:0]       frame,
  input  logic [OFS_W-1:0]         ofs,
  input  logic                     pv,
  input  logic                     ro,
  input  logic                     wr,
  output logic [FRAME_W+OFS_W-1:0] paddr,
  output logic                     fault,
  output logic                     cause
);
  import pat_pkg::*;

  always_comb begin
    fault = !pv || (wr && ro);
    cause = pv ? CAUSE_PROTECT : CAUSE_ABSENT;
    paddr = fault ? '0 : {frame, ofs};
  end
endmodule

// File: rtl/pat_ctrl.sv
module pat_ctrl #(
  parameter int LADDR_W   = 16,
  parameter int OFS_W     = 10,
  parameter int FRAME_W   = 8,
  parameter int PT_ADDR_W = 20,
  parameter int PTE_BYTES = 4,
  localparam int VPN_W     = LADDR_W - OFS_W,
  localparam int PTE_W     = FRAME_W + 2,
  localparam int PA_W      = FRAME_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [LADDR_W-1:0]   req_addr,
  input  logic                 req_write,
  input  logic [PT_ADDR_W-1:0] pt_base,
  output logic                 pt_req,
  output logic [PT_ADDR_W-1:0] pt_addr,
  input  logic                 pt_rvalid,
  input  logic [PTE_W-1:0]     pt_rdata,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 fault_valid,
  output logic                 fault_cause,
  output logic [VPN_W-1:0]     lk_vpn,
  input  logic                 lk_hit,
  input  logic [FRAME_W-1:0]   lk_frame,
  input  logic                 lk_pv,
  input  logic                 lk_ro,
  output logic                 fill_en,
  output logic [FRAME_W-1:0]   fill_frame,
  output logic                 fill_pv,
  output logic                 fill_ro,
  output logic [FRAME_W-1:0]   x_frame,
  output logic [OFS_W-1:0]     x_ofs,
  output logic                 x_pv,
  output logic                 x_ro,
  output logic                 x_wr,
  input  logic [PA_W-1:0]      x_paddr,
  input  logic                 x_fault,
  input  logic                 x_cause
);
  import pat_pkg::*;

  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  pat_state_e        state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              wr_q;
  logic              accept;
  logic              from_pt;
  logic              done;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lk_vpn    = vpn_q;
  assign from_pt   = (state_q == ST_WAIT);

  assign fill_frame = pt_rdata[FRAME_W-1:0];
  assign fill_ro    = pt_rdata[FRAME_W];
  assign fill_pv    = pt_rdata[FRAME_W+1];
  assign fill_en    = from_pt && pt_rvalid;

  assign x_frame = from_pt ? fill_frame : lk_frame;
  assign x_pv    = from_pt ? fill_pv    : lk_pv;
  assign x_ro    = from_pt ? fill_ro    : lk_ro;
  assign x_ofs   = ofs_q;
  assign x_wr    = wr_q;

  assign done = ((state_q == ST_LOOK) && lk_hit) || fill_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pt_req      <= 1'b0;
      pt_addr     <= '0;
      rsp_valid   <= 1'b0;
      fault_valid <= 1'b0;
      rsp_paddr   <= '0;
      fault_cause <= 1'b0;
    end else begin
      rsp_valid   <= done && !x_fault;
      fault_valid <= done && x_fault;
      pt_req      <= 1'b0;
      if (done) begin
        rsp_paddr   <= x_paddr;
        fault_cause <= x_cause;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (accept) state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (lk_hit) begin
            state_q <= ST_IDLE;
          end else begin
            pt_req  <= 1'b1;
            pt_addr <= pt_base + (PT_ADDR_W'(vpn_q) << PTE_SHIFT);
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (pt_rvalid) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      vpn_q <= req_addr[LADDR_W-1:OFS_W];
      ofs_q <= req_addr[OFS_W-1:0];
      wr_q  <= req_write;
    end
  end

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fault_valid)); // R12

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R12

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid); // R12

  AST_WALK_PULSE: assert property (@(posedge clk) disable iff (rst)
    pt_req |=> !pt_req); // R5

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (rsp_paddr == '0)); // R6

  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_LOOK) && lk_hit) |=> (!pt_req && (rsp_valid || fault_valid))); // R4

  AST_STRAY_DATA: assert property (@(posedge clk) disable iff (rst)
    (pt_rvalid && (state_q == ST_IDLE)) |=> (!rsp_valid && !fault_valid)); // R11
endmodule

// File: rtl/pat_translator.sv
module pat_translator #(
  parameter int LADDR_W   = 16,
  parameter int OFS_W     = 10,
  parameter int FRAME_W   = 8,
  parameter int PT_ADDR_W = 20,
  parameter int PTE_BYTES = 4,
  parameter int TLB_N     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tlb_flush,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [LADDR_W-1:0]         req_addr,
  input  logic                       req_write,
  input  logic [PT_ADDR_W-1:0]       pt_base,
  output logic                       pt_req,
  output logic [PT_ADDR_W-1:0]       pt_addr,
  input  logic                       pt_rvalid,
  input  logic [FRAME_W+1:0]         pt_rdata,
  output logic                       rsp_valid,
  output logic [FRAME_W+OFS_W-1:0]   rsp_paddr,
  output logic                       fault_valid,
  output logic                       fault_cause
);
  localparam int VPN_W = LADDR_W - OFS_W;
  localparam int PA_W  = FRAME_W + OFS_W;

  logic [VPN_W-1:0]   lk_vpn;
  logic               lk_hit, lk_pv, lk_ro;
  logic [FRAME_W-1:0] lk_frame;
  logic               fill_en, fill_pv, fill_ro;
  logic [FRAME_W-1:0] fill_frame;
  logic [FRAME_W-1:0] x_frame;
  logic [OFS_W-1:0]   x_ofs;
  logic               x_pv, x_ro, x_wr, x_fault, x_cause;
  logic [PA_W-1:0]    x_paddr;

  pat_ctrl #(
    .LADDR_W(LADDR_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W),
    .PT_ADDR_W(PT_ADDR_W), .PTE_BYTES(PTE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .pt_base(pt_base), .pt_req(pt_req), .pt_addr(pt_addr),
    .pt_rvalid(pt_rvalid), .pt_rdata(pt_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .fault_valid(fault_valid), .fault_cause(fault_cause),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .lk_pv(lk_pv), .lk_ro(lk_ro),
    .fill_en(fill_en), .fill_frame(fill_frame),
    .fill_pv(fill_pv), .fill_ro(fill_ro),
    .x_frame(x_frame), .x_ofs(x_ofs), .x_pv(x_pv), .x_ro(x_ro), .x_wr(x_wr),
    .x_paddr(x_paddr), .x_fault(x_fault), .x_cause(x_cause)
  );

  pat_tlb #(
    .TLB_N(TLB_N), .VPN_W(VPN_W), .FRAME_W(FRAME_W)
  ) u_tlb (
    .clk(clk), .rst(rst), .flush(tlb_flush),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .lk_pv(lk_pv), .lk_ro(lk_ro),
    .wr_en(fill_en), .wr_vpn(lk_vpn), .wr_frame(fill_frame),
    .wr_pv(fill_pv), .wr_ro(fill_ro)
  );

  pat_xlate #(
    .FRAME_W(FRAME_W), .OFS_W(OFS_W)
  ) u_xlate (
    .frame(x_frame), .ofs(x_ofs), .pv(x_pv), .ro(x_ro), .wr(x_wr),
    .paddr(x_paddr), .fault(x_fault), .cause(x_cause)
  );
endmodule

// File: tb/tb_pat_translator.sv
module tb_pat_translator;
  localparam int CLK_PERIOD = 10;
  localparam int LADDR_W    = 8;
  localparam int OFS_W      = 4;
  localparam int FRAME_W    = 6;
  localparam int PT_ADDR_W  = 12;
  localparam int PTE_BYTES  = 2;
  localparam int TLB_N      = 4;
  localparam int NPAGES     = 1 << (LADDR_W - OFS_W);
  localparam int PT_BASE    = 12'h340;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tlb_flush = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LADDR_W-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [PT_ADDR_W-1:0] pt_base = PT_ADDR_W'(PT_BASE);
  logic pt_req;
  logic [PT_ADDR_W-1:0] pt_addr;
  logic pt_rvalid = 1'b0;
  logic [FRAME_W+1:0] pt_rdata = '0;
  logic rsp_valid;
  logic [FRAME_W+OFS_W-1:0] rsp_paddr;
  logic fault_valid;
  logic fault_cause;

  int n_chk = 0;
  int n_bad = 0;

  // reference state: page table and cache image
  int  pg_frame [NPAGES];
  bit  pg_ro    [NPAGES];
  bit  pg_pv    [NPAGES];
  int  m_vpn    [TLB_N];
  int  m_frame  [TLB_N];
  bit  m_ro     [TLB_N];
  bit  m_pv     [TLB_N];
  bit  m_used   [TLB_N];
  int  m_ptr = 0;

  pat_translator #(
    .LADDR_W(LADDR_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W),
    .PT_ADDR_W(PT_ADDR_W), .PTE_BYTES(PTE_BYTES), .TLB_N(TLB_N)
  ) dut (
    .clk(clk), .rst(rst), .tlb_flush(tlb_flush),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .pt_base(pt_base), .pt_req(pt_req), .pt_addr(pt_addr),
    .pt_rvalid(pt_rvalid), .pt_rdata(pt_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .fault_valid(fault_valid), .fault_cause(fault_cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk(rsp_valid == 1'b0, tag, "rsp_valid quiet", int'(rsp_valid), 0);
    chk(fault_valid == 1'b0, tag, "fault_valid quiet", int'(fault_valid), 0);
    chk(pt_req == 1'b0, tag, "pt_req quiet", int'(pt_req), 0);
  endtask

  function automatic int m_find(input int vpn);
    for (int i = 0; i < TLB_N; i++) begin
      if (m_used[i] && m_vpn[i] == vpn) return i;
    end
    return -1;
  endfunction

  // One translation, compared on every clock until its result
  task automatic xact(input int addr, input bit wr, input int lat, input string tag);
    int vpn, ofs, slot, fr, exp_pa;
    bit ro, pv, flt, cause;
    vpn  = addr >> OFS_W;
    ofs  = addr & ((1 << OFS_W) - 1);
    slot = m_find(vpn);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before take", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = LADDR_W'(addr);
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = '0;
    chk(req_ready == 1'b0, "R2", "busy after take", int'(req_ready), 0);
    quiet("R12");
    if (slot >= 0) begin
      fr = m_frame[slot]; ro = m_ro[slot]; pv = m_pv[slot];
      @(negedge clk);
      chk(pt_req == 1'b0, "R4/R9", "no walk on hit", int'(pt_req), 0);
    end else begin
      fr = pg_frame[vpn]; ro = pg_ro[vpn]; pv = pg_pv[vpn];
      @(negedge clk);
      chk(pt_req == 1'b1, "R5/R9", "walk strobe on miss", int'(pt_req), 1);
      chk(int'(pt_addr) == PT_BASE + vpn * PTE_BYTES, "R5", "walk address",
          int'(pt_addr), PT_BASE + vpn * PTE_BYTES);
      chk(rsp_valid == 1'b0 && fault_valid == 1'b0, "R5", "no result during walk",
          int'({rsp_valid, fault_valid}), 0);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        quiet("R5");
        chk(req_ready == 1'b0, "R2", "busy while waiting", int'(req_ready), 0);
      end
      pt_rvalid = 1'b1;
      pt_rdata  = {pv, ro, FRAME_W'(fr)};
      @(negedge clk);
      pt_rvalid = 1'b0;
      pt_rdata  = '1;
      m_vpn[m_ptr] = vpn; m_frame[m_ptr] = fr; m_ro[m_ptr] = ro;
      m_pv[m_ptr] = pv; m_used[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % TLB_N;
    end
    flt    = !pv || (wr && ro);
    cause  = pv;
    exp_pa = flt ? 0 : ((fr << OFS_W) | ofs);
    chk(rsp_valid == !flt, tag, "rsp_valid", int'(rsp_valid), int'(!flt));
    chk(fault_valid == flt, tag, "fault_valid", int'(fault_valid), int'(flt));
    chk(int'(rsp_paddr) == exp_pa, flt ? "R6" : "R3", "physical address",
        int'(rsp_paddr), exp_pa);
    if (flt) chk(fault_cause == cause, "R7", "fault cause", int'(fault_cause), int'(cause));
    chk(req_ready == 1'b1, "R2", "ready with result", int'(req_ready), 1);
    @(negedge clk);
    quiet("R12");
  endtask

  task automatic do_flush();
    @(negedge clk);
    tlb_flush = 1'b1;
    @(negedge clk);
    tlb_flush = 1'b0;
    quiet("R10");
    for (int i = 0; i < TLB_N; i++) m_used[i] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPAGES; p++) begin
      pg_frame[p] = (p * 5 + 3) % (1 << FRAME_W);
      pg_ro[p]    = (p % 4 == 1);
      pg_pv[p]    = (p != 9) && (p != 14);
    end
    for (int i = 0; i < TLB_N; i++) m_used[i] = 1'b0;

    repeat (3) @(negedge clk);
    quiet("R1");
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    quiet("R1");
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

    // R3 R5: first access misses; then R4 hit on same page
    xact(8'h3D, 1'b0, 1, "R5");
    xact(8'h35, 1'b1, 0, "R4");
    // R9: fill remaining slots, wrap evicts page 3
    xact(8'h50, 1'b0, 2, "R9");
    xact(8'h61, 1'b0, 0, "R9");
    xact(8'h72, 1'b0, 1, "R9");
    xact(8'h83, 1'b0, 0, "R9");
    xact(8'h3E, 1'b0, 3, "R9");
    xact(8'h6F, 1'b0, 0, "R9");
    xact(8'h57, 1'b0, 1, "R9");
    // R6 absent page, then R8 cached fault, R7 absent beats protect
    xact(8'h94, 1'b0, 0, "R6");
    xact(8'h95, 1'b1, 0, "R8");
    // R7 protected page
    xact(8'h1A, 1'b0, 2, "R7");
    xact(8'h1B, 1'b1, 0, "R7");
    // R11 stray read data while idle
    @(negedge clk);
    pt_rvalid = 1'b1;
    pt_rdata  = '1;
    @(negedge clk);
    pt_rvalid = 1'b0;
    quiet("R11");
    @(negedge clk);
    quiet("R11");
    xact(8'h1C, 1'b0, 0, "R11");
    // R10 flush then miss
    do_flush();
    xact(8'h1C, 1'b0, 1, "R10");
    xact(8'h94, 1'b1, 0, "R10");

    for (int i = 0; i < 160; i++) begin
      xact((i * 37 + 11) & 8'hFF, (i % 3) == 0, i % 4, "R3");
      if (i % 50 == 49) do_flush();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule